// File: doc/BRIEF.md
# MDIO Management Command Engine

This block is a register-driven management master for external Ethernet PHYs. It performs clause-22 reads and writes. Software programs a small bank of 16-bit registers through a single-cycle write port, with a combinational read-back port. To start a transaction, software sets one request bit in a packed command word together with the target PHY address and register number. The engine then shifts a complete management frame out on MDC/MDIO. The request bit stays set for as long as the frame is on the wire, and software polls until the bit drops.

For a write, the 16-bit value must already sit in the write-data register when the command is issued. For a read, the engine releases the data line from the turnaround onward and samples the PHY's answer. The value lands in a read-only result register once the frame ends. A configuration register holds the MDC divider, which resets to 7. It also holds a stored enable flag and a stored PHY address, which are only read back. A command written while a transaction is running is dropped.

Top module: `mdio_cmd_engine`

## Requirements
- R1: After reset the command register reads 0x0000, the configuration register reads 0x0007, MDC is low and the MDIO output enable is low.
- R2: Register select (reg_addr) 0 is configuration, 1 is command, 2 is write data, 3 is read data (read-only). In the command word, bit 14 requests a write, bit 13 requests a read, bits 12:8 hold the PHY address and bits 4:0 the register number; the other bits read 0. Writing a request bit starts a transaction. The request bit reads 1 until the frame completes and then clears by itself, while the address fields keep their values.
- R3: A frame is 64 bits, MSB first: 32 ones, start code 01, opcode (10 read, 01 write), 5-bit PHY address, 5-bit register number, turnaround, then 16 data bits. On a write the turnaround is 10 and the data is the write-data register value at the time of the command.
- R4: On a read the output enable is low for the turnaround and all 16 data bits. MDIO input is sampled on each MDC rising edge of the data bits. The 16-bit result is readable at select 3 after the request bit clears.
- R5: MDC has a period of 2×(divider+1) system clocks while a frame is in progress, and stays low when idle.
- R6: The driven MDIO value changes only while MDC is low.
- R7: A command written while a request bit is set is ignored: the fields read back unchanged and no extra frame is sent.
- R8: A command with both request bits set is carried out as a read, and reads back with only bit 13 set.
- R9: The configuration register holds the enable flag at bit 15, a PHY address at bits 12:8 and the MDC divider at bits 7:0, all read back as written. A new divider applies to the next frame.
- R10: A command write with neither request bit set starts no frame and leaves MDC low, but updates the address fields.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 16 | Register write value |
| reg_rdata | output | 16 | Read-back of the selected register |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data driven by the engine |
| mdio_oe | output | 1 | Output enable for mdio_o |
| mdio_i | input | 1 | Management data returned by the PHY |

## Verification
The assertions assume that software never rewrites the command register in the same cycle as a frame completes, and that mdio_i is meaningful only while the engine has released the line. The stimulus respects both. The bench's PHY model changes mdio_i only on MDC falling edges during the read data bits. Command writes are issued either while the engine is idle or in mid-frame, well away from the last falling edge. The divider is changed only between frames, so each measured MDC period belongs to a single setting.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;

    localparam int PHY_W      = 5;
    localparam int REG_W      = 5;
    localparam int DATA_W     = 16;
    localparam int PRE_BITS   = 32;
    localparam int TA_IDX     = PRE_BITS + 4 + PHY_W + REG_W;
    localparam int DATA_IDX   = TA_IDX + 2;
    localparam int FRAME_BITS = DATA_IDX + DATA_W;

    // command word bit positions
    localparam int CMD_WR_BIT  = 14;
    localparam int CMD_RD_BIT  = 13;
    localparam int CMD_PHY_LSB = 8;

    // configuration word bit positions
    localparam int CFG_EN_BIT  = 15;
    localparam int CFG_PHY_LSB = 8;

    typedef enum logic [1:0] {
        SEL_CFG   = 2'd0,
        SEL_CMD   = 2'd1,
        SEL_WDATA = 2'd2,
        SEL_RDATA = 2'd3
    } reg_sel_e;

    typedef enum logic {
        OP_WRITE = 1'b0,
        OP_READ  = 1'b1
    } mgmt_op_e;

    typedef struct packed {
        mgmt_op_e           op;
        logic [PHY_W-1:0]   phy;
        logic [REG_W-1:0]   regn;
        logic [DATA_W-1:0]  wdata;
    } mgmt_req_t;

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_p,
    output logic             fall_p
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             mdc;
    } div_st_t;

    div_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        rise_p = 1'b0;
        fall_p = 1'b0;
        if (!run) begin
            st_d.cnt = '0;
            st_d.mdc = 1'b0;
        end else if (st_q.cnt == div) begin
            st_d.cnt = '0;
            st_d.mdc = ~st_q.mdc;
            rise_p   = ~st_q.mdc;
            fall_p   = st_q.mdc;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mdc = st_q.mdc;

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  mgmt_req_t         req,
    input  logic              rise_p,
    input  logic              fall_p,
    input  logic              mdio_i,
    output logic              busy,
    output logic              done_p,
    output logic              rd_valid_p,
    output logic [DATA_W-1:0] rd_data,
    output logic              mdio_o,
    output logic              mdio_oe
);

    localparam int IDX_W = $clog2(FRAME_BITS);
    localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(FRAME_BITS - 1);
    localparam logic [IDX_W-1:0] TA_POS   = IDX_W'(TA_IDX);
    localparam logic [IDX_W-1:0] DATA_POS = IDX_W'(DATA_IDX);

    typedef struct packed {
        logic                  busy;
        logic                  is_read;
        logic [IDX_W-1:0]      idx;
        logic [FRAME_BITS-1:0] shreg;
        logic                  mdio_o;
        logic                  oe;
        logic [DATA_W-1:0]     cap;
    } seq_st_t;

    seq_st_t st_d, st_q;
    logic [FRAME_BITS-1:0] frame;
    logic [1:0]            opcode;
    logic [1:0]            ta_bits;
    logic [DATA_W-1:0]     data_bits;
    logic [IDX_W-1:0]      idx_next;

    always_comb begin
        opcode    = (req.op == OP_READ) ? 2'b10 : 2'b01;
        ta_bits   = (req.op == OP_READ) ? 2'b00 : 2'b10;
        data_bits = (req.op == OP_READ) ? '0 : req.wdata;
        frame     = {{PRE_BITS{1'b1}}, 2'b01, opcode, req.phy, req.regn,
                     ta_bits, data_bits};
    end

    always_comb begin
        st_d       = st_q;
        done_p     = 1'b0;
        rd_valid_p = 1'b0;
        idx_next   = st_q.idx + 1'b1;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy    = 1'b1;
                st_d.is_read = (req.op == OP_READ);
                st_d.idx     = '0;
                st_d.shreg   = frame;
                st_d.mdio_o  = frame[FRAME_BITS-1];
                st_d.oe      = 1'b1;
                st_d.cap     = '0;
            end
        end else begin
            if (rise_p && st_q.is_read && (st_q.idx >= DATA_POS)) begin
                st_d.cap = {st_q.cap[DATA_W-2:0], mdio_i};
            end
            if (fall_p) begin
                if (st_q.idx == LAST_POS) begin
                    st_d.busy   = 1'b0;
                    st_d.oe     = 1'b0;
                    st_d.mdio_o = 1'b0;
                    done_p      = 1'b1;
                    rd_valid_p  = st_q.is_read;
                end else begin
                    st_d.idx    = idx_next;
                    st_d.shreg  = {st_q.shreg[FRAME_BITS-2:0], 1'b0};
                    st_d.mdio_o = st_q.shreg[FRAME_BITS-2];
                    st_d.oe     = ~(st_q.is_read && (idx_next >= TA_POS));
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy    = st_q.busy;
    assign rd_data = st_q.cap;
    assign mdio_o  = st_q.mdio_o;
    assign mdio_oe = st_q.oe;

endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine
    import mdio_cmd_pkg::*;
#(
    parameter int          DIV_W     = 8,
    parameter int unsigned DIV_RESET = 7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);

    typedef struct packed {
        logic              cfg_en;
        logic [PHY_W-1:0]  cfg_phy;
        logic [DIV_W-1:0]  cfg_div;
        logic              req_wr;
        logic              req_rd;
        logic [PHY_W-1:0]  cmd_phy;
        logic [REG_W-1:0]  cmd_reg;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } eng_st_t;

    eng_st_t st_d, st_q;

    logic              pending;
    logic              cmd_accept;
    logic              want_rd;
    logic              want_wr;
    logic              seq_start;
    mgmt_req_t         seq_req;
    logic              seq_busy;
    logic              seq_done;
    logic              seq_rd_valid;
    logic [DATA_W-1:0] seq_rd_data;
    logic              rise_p;
    logic              fall_p;

    assign pending = st_q.req_wr | st_q.req_rd;

    always_comb begin
        want_rd    = reg_wdata[CMD_RD_BIT];
        want_wr    = reg_wdata[CMD_WR_BIT] & ~reg_wdata[CMD_RD_BIT];
        cmd_accept = reg_wr && (reg_addr == SEL_CMD) && !pending;
        seq_start  = cmd_accept && (want_rd || want_wr);

        seq_req.op    = want_rd ? OP_READ : OP_WRITE;
        seq_req.phy   = reg_wdata[CMD_PHY_LSB +: PHY_W];
        seq_req.regn  = reg_wdata[REG_W-1:0];
        seq_req.wdata = st_q.wdata;
    end

    always_comb begin
        st_d = st_q;
        if (reg_wr) begin
            unique case (reg_addr)
                SEL_CFG: begin
                    st_d.cfg_en  = reg_wdata[CFG_EN_BIT];
                    st_d.cfg_phy = reg_wdata[CFG_PHY_LSB +: PHY_W];
                    st_d.cfg_div = reg_wdata[DIV_W-1:0];
                end
                SEL_CMD: begin
                    if (cmd_accept) begin
                        st_d.cmd_phy = reg_wdata[CMD_PHY_LSB +: PHY_W];
                        st_d.cmd_reg = reg_wdata[REG_W-1:0];
                        st_d.req_rd  = want_rd;
                        st_d.req_wr  = want_wr;
                    end
                end
                SEL_WDATA: st_d.wdata = reg_wdata;
                default: ;
            endcase
        end
        if (seq_done) begin
            st_d.req_rd = 1'b0;
            st_d.req_wr = 1'b0;
        end
        if (seq_rd_valid) begin
            st_d.rdata = seq_rd_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.cfg_div <= DIV_W'(DIV_RESET);
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            SEL_CFG: begin
                reg_rdata[CFG_EN_BIT]               = st_q.cfg_en;
                reg_rdata[CFG_PHY_LSB +: PHY_W]     = st_q.cfg_phy;
                reg_rdata[DIV_W-1:0]                = st_q.cfg_div;
            end
            SEL_CMD: begin
                reg_rdata[CMD_WR_BIT]               = st_q.req_wr;
                reg_rdata[CMD_RD_BIT]               = st_q.req_rd;
                reg_rdata[CMD_PHY_LSB +: PHY_W]     = st_q.cmd_phy;
                reg_rdata[REG_W-1:0]                = st_q.cmd_reg;
            end
            SEL_WDATA: reg_rdata = st_q.wdata;
            SEL_RDATA: reg_rdata = st_q.rdata;
            default:   reg_rdata = '0;
        endcase
    end

    mdio_clk_div #(
        .DIV_W (DIV_W)
    ) clk_div_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (seq_busy),
        .div    (st_q.cfg_div),
        .mdc    (mdc),
        .rise_p (rise_p),
        .fall_p (fall_p)
    );

    mdio_frame_seq frame_seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (seq_start),
        .req        (seq_req),
        .rise_p     (rise_p),
        .fall_p     (fall_p),
        .mdio_i     (mdio_i),
        .busy       (seq_busy),
        .done_p     (seq_done),
        .rd_valid_p (seq_rd_valid),
        .rd_data    (seq_rd_data),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe)
    );

endmodule

// File: rtl/mdio_cmd_engine_chk.sv
module mdio_cmd_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [1:0]  reg_addr,
    input logic [15:0] reg_wdata,
    input logic [15:0] reg_rdata,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic        seq_busy
);

    logic req_wr_seen;
    logic req_rd_seen;
    logic [12:0] fields_seen;

    // observe the command word only when it is selected
    always_comb begin
        req_wr_seen = (reg_addr == 2'd1) && reg_rdata[14];
        req_rd_seen = (reg_addr == 2'd1) && reg_rdata[13];
        fields_seen = reg_rdata[12:0];
    end

    AST_MDIO_MOVES_ONLY_MDC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_oe && $past(mdio_oe) && (mdio_o != $past(mdio_o))) |-> !mdc); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_busy |-> (!mdc && !mdio_oe)); // R5

    AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_wr_seen, req_rd_seen})); // R8

    AST_START_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_addr == 2'd1) && !seq_busy && (reg_wdata[14] || reg_wdata[13]))
        |=> seq_busy); // R2

    AST_REQ_SHOWN_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_busy && (reg_addr == 2'd1)) |-> (req_wr_seen || req_rd_seen)); // R2

    AST_FIELDS_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_busy && $past(seq_busy) && (reg_addr == 2'd1) && ($past(reg_addr) == 2'd1))
        |-> $stable(fields_seen)); // R7

endmodule

bind mdio_cmd_engine mdio_cmd_engine_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .seq_busy  (seq_busy)
);

// File: tb/mdio_cmd_engine_tb_top.sv
module mdio_cmd_engine_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;
    logic        mdio_i = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    mdio_cmd_engine dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (mdio_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic [63:0] bits;
        bit          rd;
    } exp_frame_t;

    exp_frame_t exp_q[$];
    exp_frame_t cur;
    logic [15:0] phy_val = 16'h0;

    int  cyc = 0;
    int  last_rise_cyc = 0;
    int  last_period = 0;
    int  rise_cnt = 0;
    int  fall_cnt = 0;
    int  total_rises = 0;
    int  frame_errs = 0;
    int  high_moves = 0;
    logic mdc_prev = 1'b0;
    logic mdio_prev = 1'b0;

    task automatic check(input string tag, input bit ok,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // monitor and PHY model, both away from the active edge
    always @(negedge clk) begin
        if (mdc && mdc_prev && mdio_oe && (mdio_o !== mdio_prev)) high_moves++;
        if (mdc && !mdc_prev) begin
            last_period   = cyc - last_rise_cyc;
            last_rise_cyc = cyc;
            total_rises++;
            if (rise_cnt == 0) begin
                if (exp_q.size() == 0) begin
                    check("R7 unexpected frame started", 1'b0, 32'd1, 32'd0);
                    cur.bits = '0;
                    cur.rd   = 1'b0;
                end else begin
                    cur = exp_q.pop_front();
                end
                frame_errs = 0;
            end
            if (cur.rd && rise_cnt >= 46) begin
                if (mdio_oe !== 1'b0) frame_errs++;
            end else begin
                if (mdio_oe !== 1'b1 || mdio_o !== cur.bits[63-rise_cnt]) frame_errs++;
            end
            rise_cnt++;
            if (rise_cnt == 64) begin
                // R3 frame content, R4 line released on reads
                check(cur.rd ? "R4 read frame bits/release" : "R3 write frame bits",
                      frame_errs == 0, frame_errs, 0);
                rise_cnt = 0;
            end
        end
        if (!mdc && mdc_prev) begin
            fall_cnt = (fall_cnt + 1) % 64;
            if (fall_cnt >= 48) mdio_i = phy_val[63-fall_cnt];
            else mdio_i = 1'b0;
        end
        mdc_prev  = mdc;
        mdio_prev = mdio_o;
    end

    task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    function automatic logic [63:0] build_frame(input bit rd, input logic [4:0] phy,
                                                input logic [4:0] rg, input logic [15:0] d);
        logic [63:0] f;
        f = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg,
             (rd ? 2'b00 : 2'b10), (rd ? 16'h0 : d)};
        return f;
    endfunction

    // driver: pushes the expected frame, then issues the command
    task automatic drive_txn(input bit rd, input logic [4:0] phy, input logic [4:0] rg,
                             input logic [15:0] d, input logic [15:0] cmd_extra);
        exp_frame_t e;
        e.bits = build_frame(rd, phy, rg, d);
        e.rd   = rd;
        exp_q.push_back(e);
        if (!rd) reg_write(2'd2, d);
        reg_write(2'd1, cmd_extra | {3'b000, phy, 3'b000, rg} |
                        (rd ? 16'h2000 : 16'h4000));
    endtask

    task automatic wait_idle(input string tag);
        logic [15:0] v;
        int n;
        n = 0;
        v = 16'h6000;
        while ((v & 16'h6000) != 0 && n < 20000) begin
            reg_read(2'd1, v);
            n++;
        end
        check(tag, (v & 16'h6000) == 0, v, v & 16'h9FFF);
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        check("watchdog expired", 1'b0, 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        logic [15:0] v;
        int rises0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        reg_read(2'd1, v);
        check("R1 command reset", v == 16'h0000, v, 16'h0000);
        reg_read(2'd0, v);
        check("R1 config reset divider 7", v == 16'h0007, v, 16'h0007);
        check("R1 idle lines", mdc === 1'b0 && mdio_oe === 1'b0, {mdc, mdio_oe}, 0);

        // R2/R3 write transaction at default divider
        drive_txn(1'b0, 5'h1A, 5'h03, 16'hA5C3, 16'h0);
        repeat (40) @(negedge clk);
        reg_read(2'd1, v);
        check("R2 write request held while busy", v == 16'h5A03, v, 16'h5A03);
        wait_idle("R2 write request clears");
        reg_read(2'd1, v);
        check("R2 fields kept after completion", v == 16'h1A03, v, 16'h1A03);
        check("R5 MDC period divider 7", last_period == 16, last_period, 16);
        check("R5 MDC low after frame", mdc === 1'b0, mdc, 0);

        // R4 read transaction
        phy_val = 16'h3C96;
        drive_txn(1'b1, 5'h01, 5'h1F, 16'h0, 16'h0);
        repeat (40) @(negedge clk);
        reg_read(2'd1, v);
        check("R2 read request held while busy", v == 16'h211F, v, 16'h211F);
        wait_idle("R2 read request clears");
        reg_read(2'd3, v);
        check("R4 read data captured", v == 16'h3C96, v, 16'h3C96);

        // R7 command while busy ignored
        drive_txn(1'b0, 5'h05, 5'h0A, 16'h0F0F, 16'h0);
        repeat (100) @(negedge clk);
        reg_write(2'd1, 16'h2304);
        reg_read(2'd1, v);
        check("R7 busy command ignored", v == 16'h450A, v, 16'h450A);
        wait_idle("R7 original frame completes");
        repeat (60) @(negedge clk);
        check("R7 no extra frame", rise_cnt == 0 && exp_q.size() == 0, rise_cnt, 0);

        // R8 both bits act as a read
        phy_val = 16'h8001;
        drive_txn(1'b1, 5'h10, 5'h11, 16'h0, 16'h4000);
        repeat (40) @(negedge clk);
        reg_read(2'd1, v);
        check("R8 only read bit shown", v == 16'h3011, v, 16'h3011);
        wait_idle("R8 request clears");
        reg_read(2'd3, v);
        check("R8 read result", v == 16'h8001, v, 16'h8001);

        // R9 configuration fields and new divider
        reg_write(2'd0, 16'h8A02);
        reg_read(2'd0, v);
        check("R9 config readback", v == 16'h8A02, v, 16'h8A02);
        phy_val = 16'h5AA5;
        drive_txn(1'b1, 5'h1F, 5'h00, 16'h0, 16'h0);
        wait_idle("R9 fast frame completes");
        check("R5 R9 MDC period divider 2", last_period == 6, last_period, 6);
        reg_read(2'd3, v);
        check("R4 read data at fast divider", v == 16'h5AA5, v, 16'h5AA5);

        // R3 write data from write-data register, all-ones pattern
        drive_txn(1'b0, 5'h00, 5'h1F, 16'hFFFF, 16'h0);
        wait_idle("R3 second write completes");
        reg_read(2'd3, v);
        check("R4 read data untouched by write", v == 16'h5AA5, v, 16'h5AA5);

        // R10 no request bit
        rises0 = total_rises;
        reg_write(2'd1, 16'h0105);
        repeat (60) @(negedge clk);
        check("R10 no frame without request", total_rises == rises0 && mdc === 1'b0,
              total_rises - rises0, 0);
        reg_read(2'd1, v);
        check("R10 fields updated", v == 16'h0105, v, 16'h0105);

        check("R6 MDIO steady while MDC high", high_moves == 0, high_moves, 0);
        check("R3 all expected frames seen", exp_q.size() == 0, exp_q.size(), 0);

        finish_run();
    end

endmodule